// File: doc/BRIEF.md
# Six-Step Cyclic Code Generator

This block is a free-running Moore state machine that walks a fixed loop of six 3-bit codes, advancing one position on every rising clock edge. The loop is neither a binary count nor a Gray count. The three state bits are driven straight to the output, so no decode logic sits between the registers and the pins.

Each state bit is held in a small synchronous JK register. The J and K controls of each register come from minimised excitation equations, not from a behavioural counter or a lookup table. A synchronous, active-high reset loads a start code. The start code defaults to `011`. A parameter can set the reset code to either of the two codes that lie outside the loop. This lets the recovery of those codes be observed through the normal ports.

Top module: `seqgen_six`

## Requirements
- R1: When `rst` is high at a rising edge, `q` equals `RESET_CODE` after that edge. With the default parameter this is `011`.
- R2: With `rst` low, each edge moves `q` one step along the loop `011`, `111`, `001`, `010`, `100`, `110`. Codes are written MSB first as `q[2] q[1] q[0]`.
- R3: From `110` the next edge returns `q` to `011`, so the loop repeats every six clocks.
- R4: `q` is the register state itself and changes only at rising clock edges.
- R5: Every state register follows JK behaviour. J=0, K=0 holds. J=1, K=0 sets. J=0, K=1 clears. J=1, K=1 inverts.
- R6: Bit 2 receives J = K = `q[1]`, so it inverts exactly when `q[1]` is 1 and holds otherwise.
- R7: Bit 1 receives J = 1 and K = (`q[2]` == `q[0]`). It therefore becomes 1 when `q[2]` differs from `q[0]`, and inverts when they are equal.
- R8: Bit 0 receives J = `q[2]` AND `q[1]` and K = NOT `q[1]`.
- R9: The unused code `000` moves to `010` on the next edge and then stays in the loop.
- R10: The unused code `101` moves to `110` on the next edge and then stays in the loop.
- R11: Reset takes priority at any point in the loop. Holding `rst` high keeps `q` at the reset code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to `RESET_CODE` |
| q | output | 3 | Current state code, MSB is bit 2 |

## Verification
The assertions check every cycle that each JK register obeys its control pair, that every loop code moves to its successor, and that both unused codes move to their defined successors. They also check that a reset edge loads the reset code. Only the bench scenarios can show that the loop actually has period six from a real reset and that random reset pulses restart it cleanly. The bench also compares the registered output against an independent table model over many clocks. Recovery from `000` and `101` is shown by bench instances whose reset code is set to those values.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;

    localparam int STATE_W = 3;

    typedef logic [STATE_W-1:0] code_t;

    typedef struct packed {
        logic j;
        logic k;
    } jk_t;

    localparam code_t START_CODE = 3'b011;

    function automatic logic jk_apply(input logic cur, input jk_t c);
        unique case ({c.j, c.k})
            2'b00:   return cur;
            2'b10:   return 1'b1;
            2'b01:   return 1'b0;
            default: return ~cur;
        endcase
    endfunction

endpackage

// File: rtl/seqgen_jk_reg.sv
module seqgen_jk_reg
    import seqgen_pkg::*;
#(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  jk_t  ctl,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) q <= INIT;
        else     q <= jk_apply(q, ctl);
    end

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.j && !ctl.k) |=> $stable(q));
    a_r5_set: assert property (@(posedge clk) disable iff (rst)
        (ctl.j && !ctl.k) |=> q);
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (!ctl.j && ctl.k) |=> !q);
    a_r5_invert: assert property (@(posedge clk) disable iff (rst)
        (ctl.j && ctl.k) |=> (q != $past(q)));

endmodule

// File: rtl/seqgen_excite.sv
module seqgen_excite
    import seqgen_pkg::*;
(
    input  code_t                 s,
    output jk_t [STATE_W-1:0]     ctl
);

    always_comb begin
        // bit 2: invert whenever the middle bit is high (R6)
        ctl[2].j = s[1];
        ctl[2].k = s[1];
        // bit 1: always pulled high, inverted when outer bits agree (R7)
        ctl[1].j = 1'b1;
        ctl[1].k = ~(s[2] ^ s[0]);
        // bit 0 (R8)
        ctl[0].j = s[2] & s[1];
        ctl[0].k = ~s[1];
    end

endmodule

// File: rtl/seqgen_six.sv
module seqgen_six
    import seqgen_pkg::*;
#(
    parameter logic [2:0] RESET_CODE = 3'b011
) (
    input  logic       clk,
    input  logic       rst,
    output logic [2:0] q
);

    code_t                state;
    jk_t [STATE_W-1:0]    ctl;

    seqgen_excite u_excite (
        .s   (state),
        .ctl (ctl)
    );

    for (genvar i = 0; i < STATE_W; i++) begin : g_bit
        seqgen_jk_reg #(.INIT(RESET_CODE[i])) u_reg (
            .clk (clk),
            .rst (rst),
            .ctl (ctl[i]),
            .q   (state[i])
        );
    end

    assign q = state;

    a_r1_reset_load: assert property (@(posedge clk)
        rst |=> (q == RESET_CODE));
    a_r2_step_a: assert property (@(posedge clk) disable iff (rst)
        (q == 3'b011) |=> (q == 3'b111));
    a_r2_step_b: assert property (@(posedge clk) disable iff (rst)
        (q == 3'b111) |=> (q == 3'b001));
    a_r2_step_c: assert property (@(posedge clk) disable iff (rst)
        (q == 3'b001) |=> (q == 3'b010));
    a_r2_step_d: assert property (@(posedge clk) disable iff (rst)
        (q == 3'b010) |=> (q == 3'b100));
    a_r2_step_e: assert property (@(posedge clk) disable iff (rst)
        (q == 3'b100) |=> (q == 3'b110));
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (q == 3'b110) |=> (q == 3'b011));
    a_r9_zero_exit: assert property (@(posedge clk) disable iff (rst)
        (q == 3'b000) |=> (q == 3'b010));
    a_r10_five_exit: assert property (@(posedge clk) disable iff (rst)
        (q == 3'b101) |=> (q == 3'b110));
    a_r6_top_hold: assert property (@(posedge clk) disable iff (rst)
        !q[1] |=> $stable(q[2]));

endmodule

// File: tb/sim_seqgen_six.sv
`timescale 1ns/1ps
module sim_seqgen_six;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] q0, q_lo, q_hi;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    seqgen_six u0 (.clk(clk), .rst(rst), .q(q0));
    seqgen_six #(.RESET_CODE(3'b000)) u_lo (.clk(clk), .rst(rst), .q(q_lo));
    seqgen_six #(.RESET_CODE(3'b101)) u_hi (.clk(clk), .rst(rst), .q(q_hi));

    function automatic logic [2:0] succ(input logic [2:0] c);
        case (c)
            3'b011: return 3'b111;
            3'b111: return 3'b001;
            3'b001: return 3'b010;
            3'b010: return 3'b100;
            3'b100: return 3'b110;
            3'b110: return 3'b011;
            3'b000: return 3'b010;
            default: return 3'b110;
        endcase
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // drive on falling edge, sample 1 ns after rising edge
    task automatic tick(input logic r);
        @(negedge clk);
        rst = r;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [2:0] model;
        logic [2:0] prev;
        rst = 1'b1;
        void'($urandom(32'd20240611));

        tick(1'b1);
        check("R1 reset code", q0, 3'b011);
        check("R9 low reset loads 000", q_lo, 3'b000);
        check("R10 high reset loads 101", q_hi, 3'b101);
        tick(1'b1);
        check("R11 reset held", q0, 3'b011);

        tick(1'b0);
        check("R2 011->111", q0, 3'b111);
        check("R9 000->010", q_lo, 3'b010);
        check("R10 101->110", q_hi, 3'b110);
        tick(1'b0);
        check("R9 stays in loop", q_lo, 3'b100);
        check("R10 stays in loop", q_hi, 3'b011);
        check("R2 111->001", q0, 3'b001);
        for (int i = 0; i < 3; i++) tick(1'b0);
        check("R2 reached 110", q0, 3'b110);
        tick(1'b0);
        check("R3 wrap to 011", q0, 3'b011);

        // period of six from this point
        for (int i = 0; i < 6; i++) tick(1'b0);
        check("R3 period six", q0, 3'b011);

        // reset mid-loop
        tick(1'b0);
        tick(1'b0);
        tick(1'b1);
        check("R11 reset mid-loop", q0, 3'b011);

        // long run against table model with random resets
        model = 3'b011;
        for (int i = 0; i < 400; i++) begin
            logic r;
            r = ($urandom % 16) == 0;
            prev = model;
            tick(r);
            model = r ? 3'b011 : succ(prev);
            check("R4 table model", q0, model);
            if (!r) begin
                checks++;
                if (q0[2] !== (prev[1] ? ~prev[2] : prev[2])) begin
                    errors++;
                    $display("FAIL R6 bit2: got %b expected %b", q0[2], prev[1] ? ~prev[2] : prev[2]);
                end
                checks++;
                if (q0[1] !== ((prev[2] == prev[0]) ? ~prev[1] : 1'b1)) begin
                    errors++;
                    $display("FAIL R7 bit1: got %b expected %b", q0[1], (prev[2] == prev[0]) ? ~prev[1] : 1'b1);
                end
                checks++;
                if (q0[0] !== ((prev[2] & prev[1]) ? 1'b1 : (prev[1] ? prev[0] : 1'b0))) begin
                    errors++;
                    $display("FAIL R8 bit0: got %b expected %b", q0[0],
                             (prev[2] & prev[1]) ? 1'b1 : (prev[1] ? prev[0] : 1'b0));
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule